// File: doc/BRIEF.md
# Iterative Unsigned Divider with Paired Operands

This block divides one unsigned number by another over a fixed number of clock cycles. It has two widths. In narrow mode a 16-bit dividend is divided by a 16-bit divisor. In wide mode a 32-bit dividend, made of two 16-bit halves, is divided by a 32-bit divisor that is split the same way. The quotient and the remainder come back as pairs of 16-bit halves. In narrow mode only the low halves carry results.

A one-cycle start pulse captures the mode and the four operand halves. The block then runs a restoring shift-subtract loop that settles two quotient bits per clock. A one-cycle done pulse marks the result. The time from start to done depends only on the mode, never on the operand values. A zero divisor gives a defined result: the quotient is all ones and the remainder equals the dividend.

Top module: `pair_divider`

## Requirements
- R1: With `wide`=0 the dividend is `op_a0` and the divisor is `op_b0`. The quotient appears on `quo_lo` and the remainder on `rem_lo`, and `quo_hi` and `rem_hi` are 0.
- R2: With `wide`=1 the dividend is {`op_a1`,`op_a0`} and the divisor is {`op_b1`,`op_b0`}, with the high half first. The quotient appears on {`quo_hi`,`quo_lo`} and the remainder on {`rem_hi`,`rem_lo`}.
- R3: In narrow mode a zero divisor gives `quo_lo`=0xFFFF, `rem_lo` equal to the dividend, and 0 on both high halves.
- R4: In wide mode a zero divisor gives 0xFFFF on both `quo_hi` and `quo_lo`, and {`rem_hi`,`rem_lo`} equal to the 32-bit dividend.
- R5: Let the accepting edge be the rising edge that samples `start`=1 while the block is idle. `done` becomes 1 after the 9th rising edge that follows it in narrow mode, and after the 17th in wide mode.
- R6: `done` stays high for exactly one clock cycle for each accepted start.
- R7: `busy` is 1 from the accepting edge until the edge that raises `done`. While `busy` is 1, `start` and all operand inputs are ignored.
- R8: The four result outputs change only on the edge that raises `done`. Between operations they hold their values, whatever the inputs do.
- R9: While `rst_n` is low, `busy`, `done` and all result outputs are 0.
- R10: When the divisor is not zero, the remainder is less than the divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; taken only while idle |
| wide | input | 1 | Mode: 0 selects 16-bit, 1 selects 32-bit |
| op_a0 | input | 16 | Dividend, low half |
| op_a1 | input | 16 | Dividend, high half (wide mode only) |
| op_b0 | input | 16 | Divisor, low half |
| op_b1 | input | 16 | Divisor, high half (wide mode only) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when a result becomes valid |
| quo_lo | output | 16 | Quotient, low half |
| quo_hi | output | 16 | Quotient, high half |
| rem_lo | output | 16 | Remainder, low half |
| rem_hi | output | 16 | Remainder, high half |

## Verification
The assertions check several properties on every cycle. They check the mode-dependent latency with a separate cycle counter. They check that `done` is a single-cycle pulse, that the results change only on completion, and that the captured divisor is stable while a start arrives during busy. They also check that a zero divisor gives an all-ones quotient and that any other divisor leaves a remainder below it. The exact quotient and remainder values can only be shown by the bench scenarios, which compare them with an independent model. These scenarios cover random operands in both modes, directed extremes, a start injected mid-operation and held outputs under changing inputs.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } div_mode_e;

  // Clock edges from the accepting edge to done: one per iteration plus a finish edge.
  function automatic int lat_edges(input int op_bits, input int bits_per_cyc);
    return op_bits / bits_per_cyc + 1;
  endfunction
endpackage

// File: rtl/pdiv_step.sv
module pdiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dq_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] dq_o
);
  // One restoring step: shift the next dividend bit in, subtract if it fits.
  function automatic logic [2*W-1:0] restore_step(input logic [W-1:0] rem,
                                                  input logic [W-1:0] dq,
                                                  input logic [W-1:0] dvs);
    logic [W:0] trial;
    logic       fits;
    trial = {rem, dq[W-1]};
    fits  = (trial >= {1'b0, dvs});
    if (fits) trial = trial - {1'b0, dvs};
    return {trial[W-1:0], dq[W-2:0], fits};
  endfunction

  assign {rem_o, dq_o} = restore_step(rem_i, dq_i, dvs_i);
endmodule

// File: rtl/pdiv_ctrl.sv
module pdiv_ctrl #(
  parameter int NARROW_ITERS = 8,
  parameter int WIDE_ITERS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wide,
  output logic busy,
  output logic done,
  output logic load,
  output logic step,
  output logic finish
);
  localparam int CNT_W = $clog2(WIDE_ITERS + 1);
  localparam logic [CNT_W-1:0] N_ITERS = CNT_W'(NARROW_ITERS);
  localparam logic [CNT_W-1:0] W_ITERS = CNT_W'(WIDE_ITERS);

  logic [CNT_W-1:0] cnt_q;

  assign load   = start && !busy;
  assign step   = busy && (cnt_q != '0);
  assign finish = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        cnt_q <= wide ? W_ITERS : N_ITERS;
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R7
endmodule

// File: rtl/pair_divider.sv
module pair_divider #(
  parameter int HALF_W       = 16,
  parameter int BITS_PER_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide,
  input  logic [HALF_W-1:0] op_a0,
  input  logic [HALF_W-1:0] op_a1,
  input  logic [HALF_W-1:0] op_b0,
  input  logic [HALF_W-1:0] op_b1,
  output logic              busy,
  output logic              done,
  output logic [HALF_W-1:0] quo_lo,
  output logic [HALF_W-1:0] quo_hi,
  output logic [HALF_W-1:0] rem_lo,
  output logic [HALF_W-1:0] rem_hi
);
  import pdiv_pkg::*;

  localparam int FULL_W       = 2 * HALF_W;
  localparam int NARROW_ITERS = HALF_W / BITS_PER_CYC;
  localparam int WIDE_ITERS   = FULL_W / BITS_PER_CYC;
  localparam int LAT_W        = $clog2(WIDE_ITERS + 2) + 1;
  localparam logic [LAT_W-1:0] NARROW_LAT = LAT_W'(lat_edges(HALF_W, BITS_PER_CYC));
  localparam logic [LAT_W-1:0] WIDE_LAT   = LAT_W'(lat_edges(FULL_W, BITS_PER_CYC));

  logic load, step, finish;
  logic [FULL_W-1:0] rem_q, dq_q, dvs_q;
  div_mode_e         mode_q;

  pdiv_ctrl #(.NARROW_ITERS(NARROW_ITERS), .WIDE_ITERS(WIDE_ITERS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
    .busy(busy), .done(done), .load(load), .step(step), .finish(finish)
  );

  // Chain of restoring steps evaluated in one cycle.
  logic [FULL_W-1:0] rem_c [0:BITS_PER_CYC];
  logic [FULL_W-1:0] dq_c  [0:BITS_PER_CYC];
  assign rem_c[0] = rem_q;
  assign dq_c[0]  = dq_q;

  for (genvar g = 0; g < BITS_PER_CYC; g++) begin : g_chain
    pdiv_step #(.W(FULL_W)) u_step (
      .rem_i(rem_c[g]), .dq_i(dq_c[g]), .dvs_i(dvs_q),
      .rem_o(rem_c[g+1]), .dq_o(dq_c[g+1])
    );
  end

  // Narrow dividends are left-aligned so the same loop serves both modes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dq_q   <= '0;
      dvs_q  <= '0;
      mode_q <= MODE_NARROW;
    end else if (load) begin
      rem_q  <= '0;
      mode_q <= wide ? MODE_WIDE : MODE_NARROW;
      dq_q   <= wide ? {op_a1, op_a0} : {op_a0, {HALF_W{1'b0}}};
      dvs_q  <= wide ? {op_b1, op_b0} : {{HALF_W{1'b0}}, op_b0};
    end else if (step) begin
      rem_q <= rem_c[BITS_PER_CYC];
      dq_q  <= dq_c[BITS_PER_CYC];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_lo <= '0;
      quo_hi <= '0;
      rem_lo <= '0;
      rem_hi <= '0;
    end else if (finish) begin
      quo_lo <= dq_q[HALF_W-1:0];
      quo_hi <= dq_q[FULL_W-1:HALF_W];
      rem_lo <= rem_q[HALF_W-1:0];
      rem_hi <= rem_q[FULL_W-1:HALF_W];
    end
  end

  // Independent edge counter for the latency check.
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lat_q <= '0;
    else if (load)  lat_q <= '0;
    else if (busy)  lat_q <= lat_q + 1'b1;
  end

  wire is_wide  = (mode_q == MODE_WIDE);
  wire dvs_zero = (dvs_q == '0);

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_q == (is_wide ? WIDE_LAT : NARROW_LAT)); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(dvs_q) && $stable(mode_q)); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({quo_hi, quo_lo, rem_hi, rem_lo}) |-> done); // R8
  AST_ZERO_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    done && dvs_zero && !is_wide |-> quo_lo == '1 && quo_hi == '0 && rem_hi == '0); // R3
  AST_ZERO_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    done && dvs_zero && is_wide |-> quo_lo == '1 && quo_hi == '1); // R4
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    done && !dvs_zero |-> {rem_hi, rem_lo} < dvs_q); // R10
endmodule

// File: tb/pair_divider_bench.sv
module pair_divider_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic wide = 1'b0;
  logic [15:0] op_a0 = '0, op_a1 = '0, op_b0 = '0, op_b1 = '0;
  logic busy, done;
  logic [15:0] quo_lo, quo_hi, rem_lo, rem_hi;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pair_divider u_pair_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
    .op_a0(op_a0), .op_a1(op_a1), .op_b0(op_b0), .op_b1(op_b1),
    .busy(busy), .done(done),
    .quo_lo(quo_lo), .quo_hi(quo_hi), .rem_lo(rem_lo), .rem_hi(rem_hi)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model: {quotient, remainder}, each 32 bits.
  function automatic logic [63:0] model(input bit w, input logic [15:0] a0, a1, b0, b1);
    logic [31:0] n, d, q, r;
    n = w ? {a1, a0} : {16'h0, a0};
    d = w ? {b1, b0} : {16'h0, b0};
    if (d == 32'h0) begin
      q = w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      r = n;
    end else begin
      q = n / d;
      r = n % d;
    end
    return {q, r};
  endfunction

  task automatic run_op(input string req, input bit w, input logic [15:0] a0, a1, b0, b1,
                        input bit inject);
    int n;
    logic [63:0] exp;
    logic [31:0] dv;
    exp = model(w, a0, a1, b0, b1);
    dv  = w ? {b1, b0} : {16'h0, b0};
    @(negedge clk);
    wide = w; op_a0 = a0; op_a1 = a1; op_b0 = b0; op_b1 = b1; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after accept", {63'h0, busy}, 64'h1);
    n = 0;
    do begin
      if (inject && n == 3) begin
        start = 1'b1; wide = ~w; op_a0 = ~a0; op_a1 = ~a1; op_b0 = b0 ^ 16'h5A5A; op_b1 = 16'h0001;
      end else if (inject && n == 4) begin
        start = 1'b0;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!done && n < 40);
    chk("R5 latency", 64'(n), w ? 64'd17 : 64'd9);
    chk(req, {quo_hi, quo_lo, rem_hi, rem_lo}, exp);
    if (dv != 32'h0)
      chk("R10 remainder below divisor", {63'h0, ({rem_hi, rem_lo} < dv)}, 64'h1);
    @(negedge clk);
    chk("R6 done single cycle", {63'h0, done}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    chk("R9 reset state", {46'h0, busy, done, quo_lo}, 64'h0);
    chk("R9 reset state hi", {quo_hi, rem_lo, rem_hi}, 64'h0);
    rst_n = 1'b1;

    // Directed corner cases.
    run_op("R1 narrow basic", 1'b0, 16'd1000, 16'h0, 16'd7, 16'h0, 1'b0);
    run_op("R3 narrow zero divisor", 1'b0, 16'hBEEF, 16'h1234, 16'h0, 16'h7777, 1'b0);
    run_op("R1 narrow max by one", 1'b0, 16'hFFFF, 16'h0, 16'h1, 16'h0, 1'b0);
    run_op("R1 narrow dividend below divisor", 1'b0, 16'd5, 16'hFFFF, 16'd9, 16'hFFFF, 1'b0);
    run_op("R2 wide basic", 1'b1, 16'h5678, 16'h1234, 16'h0010, 16'h0000, 1'b0);
    run_op("R4 wide zero divisor", 1'b1, 16'hCAFE, 16'hDEAD, 16'h0, 16'h0, 1'b0);
    run_op("R2 wide max by max", 1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
    run_op("R2 wide divisor high half only", 1'b1, 16'h0001, 16'h8000, 16'h0000, 16'h0003, 1'b0);

    // Start during busy must not disturb the running operation.
    run_op("R7 start ignored narrow", 1'b0, 16'd50000, 16'h0, 16'd123, 16'h0, 1'b1);
    run_op("R7 start ignored wide", 1'b1, 16'h4321, 16'h0ABC, 16'h0777, 16'h0000, 1'b1);

    // Held outputs while inputs move without start.
    held = {quo_hi, quo_lo, rem_hi, rem_lo};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      wide = i[0]; op_a0 = 16'(i * 977); op_a1 = 16'(i * 31); op_b0 = 16'(i + 1); op_b1 = 16'h0;
    end
    chk("R8 outputs held", {quo_hi, quo_lo, rem_hi, rem_lo}, held);

    // Random operands in both modes.
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a0, a1, b0, b1;
      a0 = 16'($urandom); a1 = 16'($urandom);
      b0 = 16'($urandom); b1 = 16'($urandom);
      if (i % 4 == 0) b0 = b0 & 16'h000F;
      run_op("R1 narrow random", 1'b0, a0, a1, b0, b1, 1'b0);
      if (i % 3 == 0) b1 = 16'h0;
      if (i % 5 == 0) b1 = b1 & 16'h0003;
      run_op("R2 wide random", 1'b1, a0, a1, b0, b1, 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule